// File: doc/BRIEF.md
# Front-Panel Memory Examine Sequencer

This block runs one memory read cycle each time an operator presses the examine button on a computer front panel. The button signal has already been debounced, but it can change at any time relative to the clock. The block passes it through a synchronizer. After that it steps a binary-coded Moore machine through a fixed eight-state sequence. The sequence first presets the address counter from the panel switches, lets the counter settle, and then turns on the address-bus buffer. Next it selects the RAM with its output enabled, and while the RAM drives the bus it gives one pulse to the display latches.

When the sequence ends, the machine waits until the button is released before it returns to idle. A single long press therefore produces exactly one read. All six control lines come straight from flip-flops, so downstream parts never see decode glitches. The address counter, the bus buffer, the RAM and the display latches sit outside this block.

Top module: `panel_examine_seq`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle (code 0) and sets the outputs {preset_n, busdrv_n, ram_cs_n, ram_we_n, ram_oe_n, show_strobe} to 1,1,1,1,1,0.
- R2: The request passes through SYNC_STAGES flip-flops (default 2). If the request rises between two clock edges while the machine is idle, preset_n goes low just after the third rising edge that follows.
- R3: While idle (code 0), the machine stays idle as long as the synchronized request is low.
- R4: Codes 1 (load) through 5 (strobe) each last exactly one cycle and advance to the next code whatever the request does.
- R5: The outputs as {preset_n, busdrv_n, ram_cs_n, ram_we_n, ram_oe_n, show_strobe} for each state code are: 0 111110, 1 011110, 2 111110, 3 101110, 4 100100, 5 100101, 6 100100, 7 111110.
- R6: From code 6, the machine enters code 7 (wait) if the synchronized request is high, and returns directly to idle if it is low.
- R7: In wait (code 7), the machine stays while the synchronized request is high and returns to idle once it is low. A held press therefore starts only one sequence.
- R8: ram_we_n is high in every cycle.
- R9: Each press gives exactly one show_strobe pulse, one cycle wide, and show_strobe is high only while ram_cs_n and ram_oe_n are both low.
- R10: Each press gives exactly one preset_n pulse, one cycle wide (low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| examine_req | input | 1 | Debounced examine button, asynchronous to clk |
| preset_n | output | 1 | Address counter preset strobe, active low |
| busdrv_n | output | 1 | Address bus buffer enable, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low (always inactive) |
| ram_oe_n | output | 1 | RAM output enable, active low |
| show_strobe | output | 1 | Display address/data latch pulse, active high |

## Verification
A press changes the outputs only on the third rising edge after the input rises: two edges go to the synchronizer and one to the state register. Every later step of the sequence then takes one edge. The outputs are registered from the next state, so each state's vector appears in the same cycle the state register takes that state. The bench holds a behavioural model that takes its own two-deep queue for the synchronizer and steps one state per edge. It compares all six outputs against this model on every falling edge, where the values have settled. Scenario checks sit on top of this comparison: they count falling edges for the latency, and they count pulses across whole presses.

// File: rtl/pes_pkg.sv
package pes_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_LOAD     = 3'd1,
      ST_SETTLE   = 3'd2,
      ST_DRIVE    = 3'd3,
      ST_SELECT   = 3'd4,
      ST_STROBE   = 3'd5,
      ST_UNSTROBE = 3'd6,
      ST_HOLD     = 3'd7
   } pes_state_e;

   typedef struct packed {
      logic preset_n;
      logic busdrv_n;
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic strobe;
   } pes_ctl_t;

   localparam pes_ctl_t PES_CTL_QUIET = 6'b111110;

   // Moore output decode, one vector per state code
   function automatic pes_ctl_t pes_decode(input pes_state_e s);
      pes_ctl_t c;
      c = PES_CTL_QUIET;
      unique case (s)
         ST_LOAD:     c.preset_n = 1'b0;
         ST_DRIVE:    c.busdrv_n = 1'b0;
         ST_SELECT,
         ST_UNSTROBE: begin
            c.busdrv_n = 1'b0;
            c.cs_n     = 1'b0;
            c.oe_n     = 1'b0;
         end
         ST_STROBE: begin
            c.busdrv_n = 1'b0;
            c.cs_n     = 1'b0;
            c.oe_n     = 1'b0;
            c.strobe   = 1'b1;
         end
         default:     c = PES_CTL_QUIET;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/pes_sync.sv
module pes_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pes_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i <= LAST; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= d_async;
            end
         end else begin : g_rest
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= 1'b0;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain_q[LAST];
endmodule

// File: rtl/pes_next.sv
module pes_next
   import pes_pkg::*;
(
   input  pes_state_e st_q,
   input  logic       req,
   output pes_state_e st_d
);
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:     st_d = req ? ST_LOAD : ST_IDLE;
         ST_LOAD:     st_d = ST_SETTLE;
         ST_SETTLE:   st_d = ST_DRIVE;
         ST_DRIVE:    st_d = ST_SELECT;
         ST_SELECT:   st_d = ST_STROBE;
         ST_STROBE:   st_d = ST_UNSTROBE;
         ST_UNSTROBE: st_d = req ? ST_HOLD : ST_IDLE;
         ST_HOLD:     st_d = req ? ST_HOLD : ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/pes_outgen.sv
module pes_outgen
   import pes_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  pes_state_e st_q,
   input  pes_state_e st_d,
   output pes_ctl_t   ctl
);
   generate
      if (OUT_REG) begin : g_registered
         pes_ctl_t ctl_q;
         always_ff @(posedge clk) begin
            if (rst) ctl_q <= PES_CTL_QUIET;
            else     ctl_q <= pes_decode(st_d);
         end
         assign ctl = ctl_q;
      end else begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst ^ (^st_d);
         assign ctl = pes_decode(st_q);
      end
   endgenerate
endmodule

// File: rtl/panel_examine_seq.sv
module panel_examine_seq
   import pes_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic examine_req,
   output logic preset_n,
   output logic busdrv_n,
   output logic ram_cs_n,
   output logic ram_we_n,
   output logic ram_oe_n,
   output logic show_strobe
);
   logic       req_sync;
   pes_state_e st_q;
   pes_state_e st_d;
   pes_ctl_t   ctl;

   pes_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (examine_req),
      .q_sync  (req_sync)
   );

   pes_next u_next (
      .st_q (st_q),
      .req  (req_sync),
      .st_d (st_d)
   );

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   pes_outgen #(.OUT_REG(OUT_REG)) u_out (
      .clk  (clk),
      .rst  (rst),
      .st_q (st_q),
      .st_d (st_d),
      .ctl  (ctl)
   );

   assign preset_n    = ctl.preset_n;
   assign busdrv_n    = ctl.busdrv_n;
   assign ram_cs_n    = ctl.cs_n;
   assign ram_we_n    = ctl.we_n;
   assign ram_oe_n    = ctl.oe_n;
   assign show_strobe = ctl.strobe;
endmodule

// File: rtl/pes_chk.sv
module pes_chk (
   input logic       clk,
   input logic       rst,
   input logic       req_s,
   input logic [2:0] st,
   input logic       preset_n,
   input logic       busdrv_n,
   input logic       ram_cs_n,
   input logic       ram_we_n,
   input logic       ram_oe_n,
   input logic       show_strobe
);
   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 3'd0 && !req_s) |=> (st == 3'd0));

   // R4
   advance_chk: assert property (@(posedge clk) disable iff (rst)
      (st >= 3'd1 && st <= 3'd5) |=> (st == $past(st) + 3'd1));

   // R6
   unstrobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 3'd6 && req_s) |=> (st == 3'd7));

   // R6
   unstrobe_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 3'd6 && !req_s) |=> (st == 3'd0));

   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 3'd7 && req_s) |=> (st == 3'd7));

   // R7
   wait_release_chk: assert property (@(posedge clk) disable iff (rst)
      (st == 3'd7 && !req_s) |=> (st == 3'd0));

   // R5
   preset_state_chk: assert property (@(posedge clk) disable iff (rst)
      (!preset_n) == (st == 3'd1));

   // R5
   bus_state_chk: assert property (@(posedge clk) disable iff (rst)
      (!busdrv_n) == (st >= 3'd3 && st <= 3'd6));

   // R8
   no_write_chk: assert property (@(posedge clk) disable iff (rst)
      ram_we_n);

   // R9
   strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
      show_strobe |-> (!ram_cs_n && !ram_oe_n));

   // R9
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      show_strobe |=> !show_strobe);

   // R10
   preset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      !preset_n |=> preset_n);
endmodule

bind panel_examine_seq pes_chk u_pes_chk (
   .clk         (clk),
   .rst         (rst),
   .req_s       (req_sync),
   .st          (st_q),
   .preset_n    (preset_n),
   .busdrv_n    (busdrv_n),
   .ram_cs_n    (ram_cs_n),
   .ram_we_n    (ram_we_n),
   .ram_oe_n    (ram_oe_n),
   .show_strobe (show_strobe)
);

// File: tb/test_panel_examine_seq.sv
`timescale 1ns/1ps
module test_panel_examine_seq;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic examine_req = 1'b0;
   logic preset_n, busdrv_n, ram_cs_n, ram_we_n, ram_oe_n, show_strobe;

   int n_checks = 0;
   int n_errors = 0;
   int cycles   = 0;

   always #4 clk = ~clk;

   panel_examine_seq i_panel_examine_seq (
      .clk(clk), .rst(rst), .examine_req(examine_req),
      .preset_n(preset_n), .busdrv_n(busdrv_n), .ram_cs_n(ram_cs_n),
      .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .show_strobe(show_strobe)
   );

   // behavioural reference: request queue plus state counter
   int m_state = 0;
   bit m_q[$] = '{1'b0, 1'b0};

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_state = 0;
         m_q = '{1'b0, 1'b0};
      end else begin
         bit rs;
         rs = m_q[$];
         void'(m_q.pop_back());
         m_q.push_front(examine_req);
         if (m_state == 0)      m_state = rs ? 1 : 0;
         else if (m_state < 6)  m_state = m_state + 1;
         else                   m_state = rs ? 7 : 0;
      end
   end

   function automatic logic [5:0] want_vec(int s);
      case (s)
         1: return 6'b011110;
         3: return 6'b101110;
         4: return 6'b100100;
         5: return 6'b100101;
         6: return 6'b100100;
         default: return 6'b111110;
      endcase
   endfunction

   function automatic logic [5:0] got_vec();
      return {preset_n, busdrv_n, ram_cs_n, ram_we_n, ram_oe_n, show_strobe};
   endfunction

   task automatic check(string tag, logic [5:0] got, logic [5:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s got=%b exp=%b at cycle %0d", tag, got, exp, cycles);
      end
   endtask

   // R5 R6 R7 R4: whole vector against the model at every falling edge
   int strobe_cnt = 0;
   int preset_cnt = 0;
   logic prev_strobe = 1'b0;
   logic prev_preset = 1'b1;
   always @(negedge clk) begin
      if (!rst) begin
         check("R5 R4 R6 R7 trace", got_vec(), want_vec(m_state));
         // R8
         check("R8 write idle", {5'b0, ram_we_n}, 6'b000001);
         if (show_strobe && !prev_strobe) strobe_cnt++;
         if (!preset_n && prev_preset)    preset_cnt++;
      end
      prev_strobe = show_strobe;
      prev_preset = preset_n;
   end

   task automatic idle_n(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // watchdog
   initial begin
      #100000;
      n_errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      idle_n(3);
      // R1 reset vector
      check("R1 reset", got_vec(), 6'b111110);
      rst = 1'b0;
      idle_n(1);
      check("R1 after reset", got_vec(), 6'b111110);

      // R3 idle holds with no request
      idle_n(20);
      check("R3 no preset", 6'(preset_cnt), 6'd0);

      // R2 latency, long press: R7 R9 R10
      strobe_cnt = 0; preset_cnt = 0;
      examine_req = 1'b1;
      idle_n(2);
      check("R2 not yet", {5'b0, preset_n}, 6'b000001);
      idle_n(1);
      check("R2 preset due", {5'b0, preset_n}, 6'b000000);
      idle_n(37);
      examine_req = 1'b0;
      idle_n(10);
      check("R9 one strobe held", 6'(strobe_cnt), 6'd1);
      check("R10 R7 one preset held", 6'(preset_cnt), 6'd1);

      // R4 one-cycle press still completes
      strobe_cnt = 0; preset_cnt = 0;
      examine_req = 1'b1;
      idle_n(1);
      examine_req = 1'b0;
      idle_n(15);
      check("R4 short press strobe", 6'(strobe_cnt), 6'd1);

      // R6 short press then quick re-press: direct idle return
      strobe_cnt = 0; preset_cnt = 0;
      examine_req = 1'b1;
      idle_n(4);
      examine_req = 1'b0;
      idle_n(6);
      examine_req = 1'b1;
      idle_n(3);
      examine_req = 1'b0;
      idle_n(15);
      check("R6 two presses strobe", 6'(strobe_cnt), 6'd2);
      check("R6 R10 two presses preset", 6'(preset_cnt), 6'd2);

      // R1 reset in mid-sequence
      examine_req = 1'b1;
      idle_n(5);
      rst = 1'b1;
      idle_n(1);
      check("R1 mid reset", got_vec(), 6'b111110);
      examine_req = 1'b0;
      idle_n(2);
      rst = 1'b0;
      idle_n(10);
      check("R3 idle after reset", got_vec(), 6'b111110);

      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule